// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two parallel buses, called A and B, and moves data in both directions at once. Each direction has its own capture register and its own output selector. The selector forwards either the live value arriving from the opposite bus or the value held in that direction's register. A register loads on each rising transition of its own capture clock, whatever the select and enable levels are. Software or a neighbouring controller can therefore snapshot a bus and replay the snapshot later, without touching the output path.

Each bus is modelled as a separate input, output and output-enable triplet, so no tristate nets are needed. Integration logic outside the block resolves the triplet onto a real bus.

When both directions forward live data and both are enabled, each output drives back the value it receives. With no other driver on either bus, the pair then holds its last value. The select and enable controls act combinationally on the outputs, so a change on them shows in the same cycle. The capture clocks are synchronous level inputs, and their rising transitions are detected on the system clock.

Top module: `reg_bus_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both capture registers to zero. After reset, a direction that forwards stored data and is enabled outputs 0.
- R2: The A-to-B register loads `aIn` at a system clock edge where `abCapClk` is 1 and was 0 at the previous edge. The loaded value appears on `bOut` (stored mode) from that edge on.
- R3: The B-to-A register loads `bIn` at a system clock edge where `baCapClk` is 1 and was 0 at the previous edge. The loaded value appears on `aOut` (stored mode) from that edge on.
- R4: Capture happens whatever the levels of `abSelStored`, `baSelStored`, `abEn` and `baEnN`, including when both directions are disabled.
- R5: A capture clock that stays high, or that falls, leaves its register unchanged.
- R6: A select input at 0 routes the live value from the opposite bus to the output in the same cycle. A select at 1 routes that direction's register.
- R7: `abEn` is active high. When it is 0, `bOe` is 0 and `bOut` is 0. When it is 1, `bOe` is 1.
- R8: `baEnN` is active low. When it is 1, `aOe` is 0 and `aOut` is 0. When it is 0, `aOe` is 1.
- R9: When the live and stored values of a direction are equal, toggling that direction's select leaves its output at that value. The selector includes a consensus term for this purpose.
- R10: With both selects at 0 and both directions enabled, each output equals the value on the opposite input. An external bus model that feeds outputs back to inputs therefore keeps its value after every external driver is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| abCapClk | input | 1 | Capture clock for the A-to-B register; its rising transition loads |
| baCapClk | input | 1 | Capture clock for the B-to-A register; its rising transition loads |
| abSelStored | input | 1 | A-to-B select: 0 live, 1 stored |
| baSelStored | input | 1 | B-to-A select: 0 live, 1 stored |
| abEn | input | 1 | A-to-B output enable, active high |
| baEnN | input | 1 | B-to-A output enable, active low |
| aIn | input | WIDTH | Value received from the A bus |
| bIn | input | WIDTH | Value received from the B bus |
| aOut | output | WIDTH | Value driven toward the A bus |
| aOe | output | 1 | A bus drive enable |
| bOut | output | WIDTH | Value driven toward the B bus |
| bOe | output | 1 | B bus drive enable |

## Verification
A vector table applies a different pair of bus values on each step, and the steps cover every mix of live and stored selects and enables. A stored-mode output that still shows the old register value is distinguishable from a fresh capture or from a live value leaking through. Capture clocks are held high, dropped and raised while the block is disabled. These steps separate true edge detection and capture that ignores the enables from level-sensitive or gated loading. Directed steps toggle a select while the live and stored values match, and they reset after captures. A bus-keeper model then closes the loop: the bus value has to survive the release of the external driver and has to collapse once the enables drop.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic capAb;       // load A-to-B register this cycle
    logic capBa;       // load B-to-A register this cycle
    logic driveB;      // A-to-B direction enabled
    logic driveA;      // B-to-A direction enabled
    logic pickStoredB; // A-to-B forwards stored data
    logic pickStoredA; // B-to-A forwards stored data
  } xcvrStrobe_t;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_AB  = 0;
  localparam int unsigned DIR_BA  = 1;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        abCapClk,
  input  logic        baCapClk,
  input  logic        abSelStored,
  input  logic        baSelStored,
  input  logic        abEn,
  input  logic        baEnN,
  output xcvrStrobe_t strobe
);

  logic [NUM_DIR-1:0] capLevel;
  logic [NUM_DIR-1:0] capPrev;
  logic [NUM_DIR-1:0] capRise;

  assign capLevel[DIR_AB] = abCapClk;
  assign capLevel[DIR_BA] = baCapClk;

  // One edge detector per direction; the previous level is tracked even
  // in reset so that a clock held high through reset does not load.
  for (genvar d = 0; d < NUM_DIR; d++) begin : gEdge
    always_ff @(posedge clk) begin
      capPrev[d] <= capLevel[d];
    end
    assign capRise[d] = capLevel[d] & ~capPrev[d];
  end

  always_comb begin
    strobe             = '0;
    strobe.capAb       = capRise[DIR_AB] & ~rst;
    strobe.capBa       = capRise[DIR_BA] & ~rst;
    strobe.driveB      = abEn;
    strobe.driveA      = ~baEnN;
    strobe.pickStoredB = abSelStored;
    strobe.pickStoredA = baSelStored;
  end

  // R5: a held-high or falling capture clock never raises a load strobe
  a_r5_no_load_on_level_ab: assert property (@(posedge clk) disable iff (rst)
    $past(abCapClk) |-> !strobe.capAb);
  a_r5_no_load_on_level_ba: assert property (@(posedge clk) disable iff (rst)
    $past(baCapClk) |-> !strobe.capBa);

endmodule

// File: rtl/xcvr_hfmux.sv
module xcvr_hfmux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);

  // Sum-of-products selector with the consensus term live&stored, so a
  // bit whose two sources agree keeps a covering term across a select change.
  for (genvar i = 0; i < WIDTH; i++) begin : gBit
    assign y[i] = (live[i] & ~sel) | (stored[i] & sel) | (live[i] & stored[i]);
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  logic [WIDTH-1:0] regAb;
  logic [WIDTH-1:0] regBa;
  logic [WIDTH-1:0] muxB;
  logic [WIDTH-1:0] muxA;

  always_ff @(posedge clk) begin
    if (rst) begin
      regAb <= '0;
      regBa <= '0;
    end else begin
      if (strobe.capAb) regAb <= aIn;
      if (strobe.capBa) regBa <= bIn;
    end
  end

  xcvr_hfmux #(.WIDTH(WIDTH)) uMuxB (
    .sel(strobe.pickStoredB), .live(aIn), .stored(regAb), .y(muxB)
  );
  xcvr_hfmux #(.WIDTH(WIDTH)) uMuxA (
    .sel(strobe.pickStoredA), .live(bIn), .stored(regBa), .y(muxA)
  );

  assign bOut = strobe.driveB ? muxB : '0;
  assign bOe  = strobe.driveB;
  assign aOut = strobe.driveA ? muxA : '0;
  assign aOe  = strobe.driveA;

  // R1: reset clears both registers
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (regAb == '0 && regBa == '0));
  // R2 / R3: a load strobe stores the opposite bus value
  a_r2_load_ab: assert property (@(posedge clk) disable iff (rst)
    strobe.capAb |=> regAb == $past(aIn));
  a_r3_load_ba: assert property (@(posedge clk) disable iff (rst)
    strobe.capBa |=> regBa == $past(bIn));
  // R5: no strobe, no change
  a_r5_keep_ab: assert property (@(posedge clk) disable iff (rst)
    !strobe.capAb |=> $stable(regAb));
  a_r5_keep_ba: assert property (@(posedge clk) disable iff (rst)
    !strobe.capBa |=> $stable(regBa));
  // R9: matching sources give that value whatever the select
  a_r9_match_ab: assert property (@(posedge clk) disable iff (rst)
    (strobe.driveB && aIn == regAb) |-> bOut == aIn);
  a_r9_match_ba: assert property (@(posedge clk) disable iff (rst)
    (strobe.driveA && bIn == regBa) |-> aOut == bIn);

endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abCapClk,
  input  logic             baCapClk,
  input  logic             abSelStored,
  input  logic             baSelStored,
  input  logic             abEn,
  input  logic             baEnN,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  xcvrStrobe_t strobe;

  xcvr_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .abCapClk(abCapClk), .baCapClk(baCapClk),
    .abSelStored(abSelStored), .baSelStored(baSelStored),
    .abEn(abEn), .baEnN(baEnN),
    .strobe(strobe)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rst(rst), .strobe(strobe),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  // R7: A-to-B enable is active high
  a_r7_ab_off: assert property (@(posedge clk) disable iff (rst)
    !abEn |-> (!bOe && bOut == '0));
  a_r7_ab_on: assert property (@(posedge clk) disable iff (rst)
    abEn |-> bOe);
  // R8: B-to-A enable is active low
  a_r8_ba_off: assert property (@(posedge clk) disable iff (rst)
    baEnN |-> (!aOe && aOut == '0));
  a_r8_ba_on: assert property (@(posedge clk) disable iff (rst)
    !baEnN |-> aOe);
  // R6 / R10: live forwarding follows the opposite input
  a_r6_live_ab: assert property (@(posedge clk) disable iff (rst)
    (abEn && !abSelStored) |-> bOut == aIn);
  a_r6_live_ba: assert property (@(posedge clk) disable iff (rst)
    (!baEnN && !baSelStored) |-> aOut == bIn);

endmodule

// File: tb/tb_reg_bus_xcvr.sv
`timescale 1ns/1ps
module tb_reg_bus_xcvr;

  localparam int W = 8;

  typedef struct packed {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         selAb;
    logic         selBa;
    logic         enAb;
    logic         enBaN;
    logic         ckAb;
    logic         ckBa;
    logic [W-1:0] expB;
    logic         expBOe;
    logic [W-1:0] expA;
    logic         expAOe;
    logic [7:0]   req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    // a      b      sAb   sBa   enAb  enBaN ckAb  ckBa  expB   oeB   expA   oeA   req
    '{8'h11, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h11, 1'b1, 8'h22, 1'b1, 8'd6},  // R6 live both
    '{8'h33, 8'h44, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h00, 1'b1, 8'd1},  // R1 stored=0, raise ckAb
    '{8'h55, 8'h66, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h33, 1'b1, 8'h00, 1'b1, 8'd2},  // R2 captured 33; ckAb held
    '{8'h77, 8'h88, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h33, 1'b1, 8'h66, 1'b1, 8'd3},  // R3 captured 66; R5 held
    '{8'h99, 8'hAA, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'd7},  // R7/R8 off; capture 99
    '{8'h12, 8'h34, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h99, 1'b1, 8'h66, 1'b1, 8'd4},  // R4 loaded while off
    '{8'h56, 8'h78, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h56, 1'b1, 8'h34, 1'b1, 8'd6},  // R6 mixed selects
    '{8'h9A, 8'hBC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 8'hBC, 1'b1, 8'd7},  // R7 ab off only
    '{8'hDE, 8'hF0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hDE, 1'b1, 8'h00, 1'b0, 8'd8}   // R8 ba off only
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         abCapClk = 1'b0, baCapClk = 1'b0;
  logic         abSelStored = 1'b0, baSelStored = 1'b0;
  logic         abEn = 1'b0, baEnN = 1'b1;
  logic [W-1:0] drvA = '0, drvB = '0;
  logic [W-1:0] aOut, bOut;
  logic         aOe, bOe;

  // Bus keeper model for the feedback test
  logic         holdMode = 1'b0;
  logic         extAEn = 1'b0;
  logic [W-1:0] extA = '0;
  logic [W-1:0] busA = '0, busB = '0;
  logic [W-1:0] aInSig, bInSig;

  assign aInSig = holdMode ? busA : drvA;
  assign bInSig = holdMode ? busB : drvB;

  always @(negedge clk) begin
    busA <= extAEn ? extA : (aOe ? aOut : '0);
    busB <= bOe ? bOut : '0;
  end

  always #10 clk = ~clk;

  reg_bus_xcvr #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst),
    .abCapClk(abCapClk), .baCapClk(baCapClk),
    .abSelStored(abSelStored), .baSelStored(baSelStored),
    .abEn(abEn), .baEnN(baEnN),
    .aIn(aInSig), .bIn(bInSig),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state with stored data selected and both enabled
    abSelStored = 1'b1; baSelStored = 1'b1; abEn = 1'b1; baEnN = 1'b0;
    drvA = 8'hC3; drvB = 8'h3C;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset bOut", bOut, 0);
    chk("R1 reset aOut", aOut, 0);
    @(negedge clk);
    rst = 1'b0;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drvA = VECS[i].a; drvB = VECS[i].b;
      abSelStored = VECS[i].selAb; baSelStored = VECS[i].selBa;
      abEn = VECS[i].enAb; baEnN = VECS[i].enBaN;
      abCapClk = VECS[i].ckAb; baCapClk = VECS[i].ckBa;
      #2;
      chk($sformatf("R%0d vec%0d bOut", VECS[i].req, i), bOut, VECS[i].expB);
      chk($sformatf("R%0d vec%0d bOe", VECS[i].req, i), bOe, VECS[i].expBOe);
      chk($sformatf("R%0d vec%0d aOut", VECS[i].req, i), aOut, VECS[i].expA);
      chk($sformatf("R%0d vec%0d aOe", VECS[i].req, i), aOe, VECS[i].expAOe);
    end
    // Registers now: A-to-B holds 99, B-to-A holds 34

    // R9: equal live and stored values survive a select toggle
    @(negedge clk);
    drvA = 8'h99; drvB = 8'h34; abEn = 1'b1; baEnN = 1'b0;
    abSelStored = 1'b1; baSelStored = 1'b1;
    #2;
    chk("R9 bOut before toggle", bOut, 8'h99);
    chk("R9 aOut before toggle", aOut, 8'h34);
    abSelStored = 1'b0; baSelStored = 1'b0;
    #1;
    chk("R9 bOut after toggle", bOut, 8'h99);
    chk("R9 aOut after toggle", aOut, 8'h34);
    abSelStored = 1'b1; baSelStored = 1'b1;
    #1;
    chk("R9 bOut toggled back", bOut, 8'h99);

    // R1: reset after captures clears the registers
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R1 second reset bOut", bOut, 0);
    chk("R1 second reset aOut", aOut, 0);

    // R10: feedback hold through the bus keeper model
    @(negedge clk);
    abSelStored = 1'b0; baSelStored = 1'b0; abEn = 1'b1; baEnN = 1'b0;
    holdMode = 1'b1; extA = 8'h5C; extAEn = 1'b1;
    repeat (3) @(negedge clk);
    extAEn = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      #2;
      chk($sformatf("R10 busA hold cycle %0d", k), busA, 8'h5C);
      chk($sformatf("R10 busB hold cycle %0d", k), busB, 8'h5C);
    end
    // Dropping both enables lets the buses float to zero
    abEn = 1'b0; baEnN = 1'b1;
    repeat (2) @(negedge clk);
    #2;
    chk("R10 busA released", busA, 0);
    chk("R10 busB released", busB, 0);

    finish_run();
  end

endmodule